// File: doc/BRIEF.md
# Toggle-Handshake Sample Domain Crossing

This block carries converter samples from a slow sample clock into a faster system clock without a FIFO. On the sample side, each sample presented with a load pulse is held in a data register, and a one-bit toggle register inverts. The held data word crosses to the system side as a plain bus, with no synchronizer on its bits. Only the toggle, and separately the over-range level, pass through multi-flop synchronizers.

On the system side, a change of the synchronized toggle in either direction marks a new sample. That change becomes a one-cycle strobe, and the data word is latched in the same cycle. Any change counts, not only a rising one, so a new word can cross on every sample clock. The scheme relies on the system clock being at least four times the sample clock. The data word is then still stable when its toggle change has passed the synchronizer. For a 10 MHz sample rate the system clock should be 50 MHz, and it must not be below 40 MHz.

The system-side capture logic is a small state machine with two states:
- `CATCH_SETTLE` is entered at system reset. In this state the edge-detect copy follows the synchronizer, but no strobe is raised.
- `CATCH_RUN` is entered from `CATCH_SETTLE` after `SYNC_STAGES+2` cycles. This is the only transition, and `CATCH_RUN` is left only through reset.

Top module: `smpx_top`

## Requirements
- R1: While `sys_rst_n` is low, and in the cycle after it is released, `out_valid`, `out_data` and `out_ovr` are all zero.
- R2: Each rising `src_clk` edge with `src_load` high registers `src_data` and inverts the internal toggle. The toggle is 0 after `src_rst_n`.
- R3: In `CATCH_RUN`, each change of the synchronized toggle, rising or falling, yields exactly one `out_valid` pulse one system cycle wide.
- R4: `out_data` changes only in a cycle where `out_valid` is high. At other times it holds the last captured word.
- R5: When the system clock is at least four times the sample clock and `SYNC_STAGES` is 2, every loaded sample appears on `out_data` exactly once, in load order. No sample is lost and none is duplicated. This holds at full rate and with gaps between loads.
- R6: `out_ovr` follows the level of `src_ovr`. The level is registered on every `src_clk` edge and then passes a `SYNC_STAGES`-deep synchronizer, independent of `out_valid`. A new level is not visible one system cycle after `src_ovr` changes. It is visible within two sample clocks plus four system cycles.
- R7: After system reset the block stays in `CATCH_SETTLE` for `SYNC_STAGES+2` cycles and raises no strobe. A toggle level that the source set while the system side was in reset is absorbed without a strobe.
- R8: A sample clock edge with `src_load` low leaves the toggle unchanged, raises no strobe and leaves `out_data` unchanged, whatever `src_data` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Sample clock |
| src_rst_n | input | 1 | Sample-domain reset, active low, asynchronous |
| src_load | input | 1 | A new sample is present on `src_data` this cycle |
| src_data | input | DATA_W | Sample word from the converter |
| src_ovr | input | 1 | Over-range level from the converter |
| sys_clk | input | 1 | System clock, at least 4x `src_clk` |
| sys_rst_n | input | 1 | System-domain reset, active low, asynchronous |
| out_data | output | DATA_W | Captured sample word |
| out_ovr | output | 1 | Synchronized over-range level |
| out_valid | output | 1 | One-cycle strobe: `out_data` holds a new sample |

## Verification
The bench builds the block with `DATA_W` = 8 and `SYNC_STAGES` = 2. The narrow word lets the computed data patterns reach both all-zero and all-one words as well as alternating bit patterns. The shallow synchronizer places the worst-case capture delay of three system edges inside the four-cycle window that a ratio of exactly four allows.

The bench sweeps the ratio from exactly four up to ten, using non-integer periods so that the clock phase drifts. At each ratio it uses three load patterns and checks the output stream for order, loss and duplicates. It also tests:
- a system reset while a toggle change is pending;
- over-range latency in both directions;
- data movement with no load.

// File: rtl/smpx_pkg.sv
package smpx_pkg;

    // System-side capture states
    typedef enum logic [0:0] {
        CATCH_SETTLE = 1'b0,
        CATCH_RUN    = 1'b1
    } catch_state_e;

    // Cycles spent settling after reset, derived from synchronizer depth
    function automatic int settle_cycles(input int stages);
        return stages + 2;
    endfunction

endpackage

// File: rtl/smpx_sync.sv
// Multi-flop level synchronizer, one chain per bit.
module smpx_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= '0;
                else        chain[0] <= d_async;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/smpx_launch.sv
// Sample-domain side: hold register for the word, toggle per load,
// registered over-range level.
module smpx_launch #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ovr_in,
    output logic [DATA_W-1:0] data_hold,
    output logic              tog,
    output logic              ovr_hold
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_hold <= '0;
            tog       <= 1'b0;
        end else if (load) begin
            data_hold <= data_in;
            tog       <= ~tog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovr_hold <= 1'b0;
        else        ovr_hold <= ovr_in;
    end
endmodule

// File: rtl/smpx_catch.sv
// System-domain side: settle/run state machine, toggle edge detect,
// strobe and data capture in the same cycle.
module smpx_catch
    import smpx_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tog_sync,
    input  logic [DATA_W-1:0] data_bus,
    output logic [DATA_W-1:0] data_q,
    output logic              valid_q,
    output logic              settling
);
    localparam int SETTLE_LEN = settle_cycles(STAGES);
    localparam int CNT_W      = $clog2(SETTLE_LEN + 1);

    catch_state_e     state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             tog_seen;
    logic             flip;
    logic             take;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CATCH_SETTLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            CATCH_SETTLE: begin
                if (cnt == CNT_W'(SETTLE_LEN - 1)) begin
                    state_nx = CATCH_RUN;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            CATCH_RUN: begin
                state_nx = CATCH_RUN;
            end
            default: begin
                state_nx = CATCH_SETTLE;
                cnt_nx   = '0;
            end
        endcase
    end

    assign flip     = tog_sync ^ tog_seen;
    assign take     = (state == CATCH_RUN) && flip;
    assign settling = (state == CATCH_SETTLE);

    // Outputs: edge copy always follows; strobe and word together
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_seen <= 1'b0;
            valid_q  <= 1'b0;
            data_q   <= '0;
        end else begin
            tog_seen <= tog_sync;
            valid_q  <= take;
            if (take) data_q <= data_bus;
        end
    end
endmodule

// File: rtl/smpx_top.sv
module smpx_top #(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              src_load,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_ovr,
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    output logic [DATA_W-1:0] out_data,
    output logic              out_ovr,
    output logic              out_valid
);
    logic [DATA_W-1:0] launch_data;
    logic              launch_tog;
    logic              launch_ovr;
    logic [1:0]        sync_in;
    logic [1:0]        sync_out;
    logic              catch_settling;

    smpx_launch #(.DATA_W(DATA_W)) u_launch (
        .clk       (src_clk),
        .rst_n     (src_rst_n),
        .load      (src_load),
        .data_in   (src_data),
        .ovr_in    (src_ovr),
        .data_hold (launch_data),
        .tog       (launch_tog),
        .ovr_hold  (launch_ovr)
    );

    // Toggle in bit 0, over-range in bit 1: independent chains
    assign sync_in = {launch_ovr, launch_tog};

    smpx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (sys_clk),
        .rst_n   (sys_rst_n),
        .d_async (sync_in),
        .q_sync  (sync_out)
    );

    assign out_ovr = sync_out[1];

    smpx_catch #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_catch (
        .clk      (sys_clk),
        .rst_n    (sys_rst_n),
        .tog_sync (sync_out[0]),
        .data_bus (launch_data),
        .data_q   (out_data),
        .valid_q  (out_valid),
        .settling (catch_settling)
    );
endmodule

// File: rtl/smpx_top_chk.sv
module smpx_top_chk #(
    parameter int DATA_W = 12
) (
    input logic              src_clk,
    input logic              src_rst_n,
    input logic              src_load,
    input logic              launch_tog,
    input logic              sys_clk,
    input logic              sys_rst_n,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              catch_settling
);
    // R2
    launch_flip_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        src_load |=> (launch_tog != $past(launch_tog)));

    // R8
    launch_hold_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        !src_load |=> $stable(launch_tog));

    // R3
    strobe_width_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        out_valid |=> !out_valid);

    // R4
    data_hold_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !out_valid |-> $stable(out_data));

    // R7
    settle_quiet_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        catch_settling |-> !out_valid);
endmodule

bind smpx_top smpx_top_chk #(.DATA_W(DATA_W)) u_chk (
    .src_clk        (src_clk),
    .src_rst_n      (src_rst_n),
    .src_load       (src_load),
    .launch_tog     (launch_tog),
    .sys_clk        (sys_clk),
    .sys_rst_n      (sys_rst_n),
    .out_valid      (out_valid),
    .out_data       (out_data),
    .catch_settling (catch_settling)
);

// File: tb/sim_smpx_top.sv
`timescale 1ns/1ps
module sim_smpx_top;
    localparam int DW = 8;

    logic          sys_clk = 1'b0;
    logic          src_clk = 1'b0;
    logic          sys_rst_n = 1'b0;
    logic          src_rst_n = 1'b0;
    logic          src_load = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic          src_ovr = 1'b0;
    logic [DW-1:0] out_data;
    logic          out_ovr;
    logic          out_valid;

    real src_half = 16.0;
    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  done = 0;

    logic [DW-1:0] exp_mem [1024];
    int  wr = 0;
    int  rd = 0;
    int  load_cnt = 0;
    int  valid_seen = 0;
    bit  quiet_win = 0;
    bit  prev_valid = 0;

    smpx_top #(.DATA_W(DW), .SYNC_STAGES(2)) u0 (
        .src_clk   (src_clk),
        .src_rst_n (src_rst_n),
        .src_load  (src_load),
        .src_data  (src_data),
        .src_ovr   (src_ovr),
        .sys_clk   (sys_clk),
        .sys_rst_n (sys_rst_n),
        .out_data  (out_data),
        .out_ovr   (out_ovr),
        .out_valid (out_valid)
    );

    always #4 sys_clk = ~sys_clk;
    initial forever #(src_half) src_clk = ~src_clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [DW-1:0] pat_val(input int ph, input int k);
        if (k == 0) return 8'h00;
        if (k == 1) return 8'hFF;
        if (k == 2) return 8'h55;
        if (k == 3) return 8'hAA;
        return DW'((k * 37 + ph * 11 + 5) & 255);
    endfunction

    // Output monitor: order, duplicates, strobe width, settle silence
    always @(negedge sys_clk) begin
        if (sys_rst_n && out_valid) begin
            valid_seen++;
            check(!prev_valid, "R3", "strobe wider than one cycle", 2, 1);
            if (quiet_win)
                check(0, "R7", "strobe during settle", 1, 0);
            else if (rd < wr) begin
                check(out_data == exp_mem[rd], "R5", "sample word",
                      int'(out_data), int'(exp_mem[rd]));
                rd++;
            end else
                check(0, "R5", "duplicate or spurious strobe", int'(out_data), -1);
        end
        prev_valid = sys_rst_n && out_valid;
    end

    always @(posedge sys_clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            check(0, "WATCHDOG", "run did not finish", cyc, 150000);
            finish_run();
        end
    end

    // pat 0: every cycle, 1: every other, 2: bursts of 3 then 2 idle
    task automatic send(input int ph, input int pat, input int n, input bit record);
        int k = 0;
        for (int i = 0; i < n; i++) begin
            bit ld;
            @(negedge src_clk);
            ld = (pat == 0) || (pat == 1 && (i % 2 == 0)) || (pat == 2 && (i % 5 < 3));
            if (ld) begin
                src_data = pat_val(ph, k);
                src_load = 1'b1;
                load_cnt++;
                if (record) begin exp_mem[wr] = src_data; wr++; end
                k++;
            end else begin
                src_load = 1'b0;
                src_data = ~src_data;
            end
        end
        @(negedge src_clk);
        src_load = 1'b0;
    endtask

    task automatic drain(input string tag);
        repeat (6) @(negedge src_clk);
        @(negedge sys_clk);
        check(rd == wr, "R5", tag, rd, wr);
    endtask

    initial begin
        real halves [6] = '{16.0, 17.3, 19.9, 24.1, 30.7, 40.0};
        int vs;
        logic [DW-1:0] last;

        repeat (5) @(negedge sys_clk);
        // R1 reset state
        check(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
        check(out_data == 0, "R1", "out_data in reset", out_data, 0);
        check(out_ovr == 0, "R1", "out_ovr in reset", out_ovr, 0);
        src_rst_n = 1'b1;
        sys_rst_n = 1'b1;
        @(negedge sys_clk);
        check(out_valid == 0 && out_data == 0, "R1", "first cycle after reset",
              int'(out_data), 0);
        repeat (10) @(negedge sys_clk);

        // R5 sweep: ratios 4..10, three load patterns
        for (int r = 0; r < 6; r++) begin
            src_half = halves[r];
            repeat (2) @(negedge src_clk);
            for (int p = 0; p < 3; p++) begin
                send(r * 3 + p, p, 48, 1);
                drain("R5 no loss after phase");
            end
        end

        // R8 / R4: data moves without load
        src_half = 20.0;
        repeat (2) @(negedge src_clk);
        last = out_data;
        vs = valid_seen;
        for (int i = 0; i < 20; i++) begin
            @(negedge src_clk);
            src_load = 1'b0;
            src_data = DW'(i * 53 + 7);
        end
        repeat (4) @(negedge src_clk);
        @(negedge sys_clk);
        check(valid_seen == vs, "R8", "strobes without load", valid_seen - vs, 0);
        check(out_data == last, "R4", "word held without strobe", int'(out_data), int'(last));

        // R6 over-range, both directions
        @(negedge src_clk);
        src_ovr = 1'b1;
        @(negedge sys_clk);
        check(out_ovr == 0, "R6", "over-range too early", out_ovr, 0);
        repeat (2) @(negedge src_clk);
        repeat (4) @(negedge sys_clk);
        check(out_ovr == 1, "R6", "over-range set", out_ovr, 1);
        send(40, 0, 8, 1);
        drain("R6 samples with over-range");
        check(out_ovr == 1, "R6", "over-range held", out_ovr, 1);
        @(negedge src_clk);
        src_ovr = 1'b0;
        @(negedge sys_clk);
        check(out_ovr == 1, "R6", "over-range cleared too early", out_ovr, 1);
        repeat (2) @(negedge src_clk);
        repeat (4) @(negedge sys_clk);
        check(out_ovr == 0, "R6", "over-range clear", out_ovr, 0);

        // R7: system reset while toggle level is 1 (odd number of loads)
        @(negedge sys_clk);
        sys_rst_n = 1'b0;
        rd = wr;
        @(negedge sys_clk);
        check(out_valid == 0 && out_data == 0, "R1", "mid-run reset", int'(out_data), 0);
        if (load_cnt % 2 == 0) send(41, 0, 1, 0);
        else                   send(41, 0, 2, 0);
        check(load_cnt % 2 == 1, "R7", "toggle parity before release", load_cnt % 2, 1);
        repeat (3) @(negedge src_clk);
        quiet_win = 1;
        vs = valid_seen;
        sys_rst_n = 1'b1;
        repeat (30) @(negedge sys_clk);
        quiet_win = 0;
        check(valid_seen == vs, "R7", "pending toggle absorbed", valid_seen - vs, 0);
        check(out_data == 0, "R7", "word after settle", int'(out_data), 0);
        send(42, 0, 16, 1);
        drain("R7 capture resumes after settle");

        finish_run();
    end
endmodule